// File: doc/BRIEF.md
# Timestamp-Triggered Pulse Train Generator

This block drives up to four square-wave outputs. Each output is tied to a free-running system time made of a seconds count and a nanoseconds count. Software programs a start time, a period and a high time for each output, then arms it with a start command. While the start is pending, a busy flag is visible. Once the system time reaches the programmed start, the flag clears and the output begins its pulse train. Period and high time are counted in sub-second increment ticks, and the `tick` input marks each tick.

The block has a simple register window. Writes complete in one cycle, with no back-pressure. Reads return combinationally for the address placed on `bus_raddr`. One shared control register carries a command for every output, one output per byte lane. A command is a strobe: it acts once and always reads back as zero. A stop command forces its output low at once.

Top module: `ptg_top`

## Requirements
- R1: After reset every output is low, every busy flag is clear, and every register reads zero except the feature register.
- R2: Output n has a register group at 0x80 + 0x10·n: start seconds at +0x0, start nanoseconds at +0x4 (bits [29:0]), interval at +0x8 and width at +0xC. Each reads back the value last accepted.
- R3: The feature register at 0x74 reports the number of implemented outputs in bits [2:0].
- R4: The control register is at 0x70. Output n owns bits [8n+7:8n], and that lane's bits [3:0] hold its command. Writing command 0x2 arms the output. While the start is pending, bit 31 of that output's start-nanoseconds register reads 1.
- R5: An armed output fires when the system time is at or past its start time. Seconds are compared first and nanoseconds only when the seconds are equal. In the cycle after the compare holds, the output is high and the busy bit reads 0.
- R6: Once running, the output is high for width+1 ticks out of every interval+1 ticks. Interval values of 3 or more are supported.
- R7: Command 0x5 drives the output low in the next cycle, clears a pending start and resets the tick count.
- R8: A write to the start-seconds or start-nanoseconds register while that output is busy is ignored.
- R9: Command fields read back as zero. A lane's 2-bit target-mode field at lane bits [6:5] is updated only by a write in which that lane's command is nonzero. A lane whose command is zero keeps its mode.
- R10: A control write is accepted only if bit 4 (the flexible-output enable) is set in the same write. Without it, no command takes effect. Once a command has been accepted, bit 4 reads back 1.
- R11: Ticks that arrive while the start is pending leave the output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle strobe marking each sub-second increment |
| tod_sec | input | 32 | System time, seconds |
| tod_nsec | input | 30 | System time, nanoseconds |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 12 | Write byte address |
| bus_wdata | input | 32 | Write data |
| bus_raddr | input | 12 | Read byte address |
| bus_rdata | output | 32 | Read data for `bus_raddr` |
| pulse_o | output | 4 | Pulse train outputs, one per output |

## Verification
The start compare is tested with time values just below the target, equal to the target, and with a later second but a smaller nanoseconds value. Together these separate a correct seconds-first compare from a plain nanoseconds compare or a strict greater-than compare. Two interval/width pairs are run, 6/3 and 4/2 ticks, over several whole periods, which exposes off-by-one errors in both the wrap and the high time. Each control write uses its own mix of lanes, commands and bit 4. This shows that commands act only in their own lane, only when bit 4 is set, and that a lane with no command keeps its mode.

// File: rtl/ptg_pkg.sv
package ptg_pkg;
  localparam logic [11:0] CTRL_ADDR = 12'h070;
  localparam logic [11:0] FEAT_ADDR = 12'h074;
  localparam logic [5:0]  GRP_HI    = 6'h02;
  localparam logic [3:0]  CMD_START = 4'h2;
  localparam logic [3:0]  CMD_STOP  = 4'h5;
  localparam int          EN_BIT    = 4;
  typedef enum logic [1:0] {
    RG_TSEC = 2'd0, RG_TNSEC = 2'd1, RG_IVAL = 2'd2, RG_WID = 2'd3
  } grp_reg_e;
endpackage

// File: rtl/ptg_cmp.sv
module ptg_cmp #(
  parameter int SEC_W = 32,
  parameter int NS_W  = 30
) (
  input  logic [SEC_W-1:0] now_sec,
  input  logic [NS_W-1:0]  now_nsec,
  input  logic [SEC_W-1:0] tgt_sec,
  input  logic [NS_W-1:0]  tgt_nsec,
  output logic             reached
);
  always_comb begin
    if (now_sec != tgt_sec) reached = (now_sec > tgt_sec);
    else                    reached = (now_nsec >= tgt_nsec);
  end
endmodule

// File: rtl/ptg_chan.sv
module ptg_chan #(
  parameter int SEC_W = 32,
  parameter int NS_W  = 30,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [SEC_W-1:0] tod_sec,
  input  logic [NS_W-1:0]  tod_nsec,
  input  logic             wr_tsec,
  input  logic             wr_tnsec,
  input  logic             wr_ival,
  input  logic             wr_wid,
  input  logic [31:0]      wdata,
  input  logic             cmd_start,
  input  logic             cmd_stop,
  output logic [SEC_W-1:0] tsec_q,
  output logic [NS_W-1:0]  tnsec_q,
  output logic [CNT_W-1:0] ival_q,
  output logic [CNT_W-1:0] wid_q,
  output logic             busy_q,
  output logic             pulse
);
  logic             run_q;
  logic [CNT_W-1:0] cnt_q;
  logic             reached;

  ptg_cmp #(.SEC_W(SEC_W), .NS_W(NS_W)) u_cmp (
    .now_sec(tod_sec), .now_nsec(tod_nsec),
    .tgt_sec(tsec_q), .tgt_nsec(tnsec_q), .reached(reached)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tsec_q  <= '0;
      tnsec_q <= '0;
      ival_q  <= '0;
      wid_q   <= '0;
    end else begin
      if (wr_tsec  && !busy_q) tsec_q  <= wdata[SEC_W-1:0];
      if (wr_tnsec && !busy_q) tnsec_q <= wdata[NS_W-1:0];
      if (wr_ival) ival_q <= wdata[CNT_W-1:0];
      if (wr_wid)  wid_q  <= wdata[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      run_q  <= 1'b0;
      cnt_q  <= '0;
    end else if (cmd_stop) begin
      busy_q <= 1'b0;
      run_q  <= 1'b0;
      cnt_q  <= '0;
    end else if (cmd_start) begin
      busy_q <= 1'b1;
      run_q  <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q && reached) begin
      busy_q <= 1'b0;
      run_q  <= 1'b1;
      cnt_q  <= '0;
    end else if (run_q && tick) begin
      cnt_q <= (cnt_q >= ival_q) ? '0 : cnt_q + 1'b1;
    end
  end

  assign pulse = run_q && (cnt_q <= wid_q);

  a_r7_stop_low: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stop |=> (!pulse && !busy_q));
  a_r5_fire: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && reached && !cmd_stop && !cmd_start) |=> (pulse && !busy_q));
  a_r8_tsec_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && wr_tsec) |=> $stable(tsec_q));
  a_r8_tnsec_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && wr_tnsec) |=> $stable(tnsec_q));
  a_r11_wait_low: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !pulse);
endmodule

// File: rtl/ptg_top.sv
module ptg_top
  import ptg_pkg::*;
#(
  parameter int NUM_OUT = 4,
  parameter int SEC_W   = 32,
  parameter int NS_W    = 30,
  parameter int CNT_W   = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic [SEC_W-1:0]   tod_sec,
  input  logic [NS_W-1:0]    tod_nsec,
  input  logic               bus_we,
  input  logic [11:0]        bus_addr,
  input  logic [31:0]        bus_wdata,
  input  logic [11:0]        bus_raddr,
  output logic [31:0]        bus_rdata,
  output logic [NUM_OUT-1:0] pulse_o
);
  localparam int LANE_W = 8;

  logic             ctrl_wr, grp_wr;
  logic [1:0]       wr_ch, rd_ch;
  grp_reg_e         wr_rg, rd_rg;
  logic             en_q;
  logic [NUM_OUT-1:0] accept;
  logic [1:0]       mode_q [NUM_OUT];
  logic [SEC_W-1:0] tsec [NUM_OUT];
  logic [NS_W-1:0]  tnsec [NUM_OUT];
  logic [CNT_W-1:0] ival [NUM_OUT];
  logic [CNT_W-1:0] wid [NUM_OUT];
  logic [NUM_OUT-1:0] busy;

  assign ctrl_wr = bus_we && (bus_addr == CTRL_ADDR);
  assign grp_wr  = bus_we && (bus_addr[11:6] == GRP_HI) && (bus_addr[1:0] == 2'b00);
  assign wr_ch   = bus_addr[5:4];
  assign wr_rg   = grp_reg_e'(bus_addr[3:2]);
  assign rd_ch   = bus_raddr[5:4];
  assign rd_rg   = grp_reg_e'(bus_raddr[3:2]);

  for (genvar n = 0; n < NUM_OUT; n++) begin : g_out
    logic [LANE_W-1:0] lane;
    logic              hit;
    assign lane      = bus_wdata[n*LANE_W +: LANE_W];
    assign accept[n] = ctrl_wr && bus_wdata[EN_BIT] && (lane[3:0] != 4'h0);
    assign hit       = grp_wr && (wr_ch == n[1:0]);

    always_ff @(posedge clk) begin
      if (!rst_n)         mode_q[n] <= 2'b00;
      else if (accept[n]) mode_q[n] <= lane[6:5];
    end

    ptg_chan #(.SEC_W(SEC_W), .NS_W(NS_W), .CNT_W(CNT_W)) u_chan (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .tod_sec(tod_sec), .tod_nsec(tod_nsec),
      .wr_tsec(hit && wr_rg == RG_TSEC),
      .wr_tnsec(hit && wr_rg == RG_TNSEC),
      .wr_ival(hit && wr_rg == RG_IVAL),
      .wr_wid(hit && wr_rg == RG_WID),
      .wdata(bus_wdata),
      .cmd_start(accept[n] && lane[3:0] == CMD_START),
      .cmd_stop(accept[n] && lane[3:0] == CMD_STOP),
      .tsec_q(tsec[n]), .tnsec_q(tnsec[n]), .ival_q(ival[n]), .wid_q(wid[n]),
      .busy_q(busy[n]), .pulse(pulse_o[n])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       en_q <= 1'b0;
    else if (|accept) en_q <= 1'b1;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_raddr == CTRL_ADDR) begin
      for (int n = 0; n < NUM_OUT; n++)
        bus_rdata[n*LANE_W + 5 +: 2] = mode_q[n];
      bus_rdata[EN_BIT] = en_q;
    end else if (bus_raddr == FEAT_ADDR) begin
      bus_rdata[2:0] = 3'(NUM_OUT);
    end else if (bus_raddr[11:6] == GRP_HI && bus_raddr[1:0] == 2'b00) begin
      for (int n = 0; n < NUM_OUT; n++) begin
        if (rd_ch == n[1:0]) begin
          case (rd_rg)
            RG_TSEC:  bus_rdata = 32'(tsec[n]);
            RG_TNSEC: bus_rdata = {busy[n], 31'(tnsec[n])};
            RG_IVAL:  bus_rdata = 32'(ival[n]);
            default:  bus_rdata = 32'(wid[n]);
          endcase
        end
      end
    end
  end

  a_r10_no_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !bus_wdata[EN_BIT]) |-> (accept == '0));
  a_r9_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && bus_wdata[3:0] == 4'h0) |=> $stable(mode_q[0]));
endmodule

// File: tb/ptg_top_tb.sv
module ptg_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [31:0] tod_sec = '0;
  logic [29:0] tod_nsec = '0;
  logic        bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [11:0] bus_raddr = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  pulse_o;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  ptg_top u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .tod_sec(tod_sec), .tod_nsec(tod_nsec),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_raddr(bus_raddr), .bus_rdata(bus_rdata), .pulse_o(pulse_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_raddr = a;
    #1 d = bus_rdata;
  endtask

  task automatic set_time(input logic [31:0] s, input logic [29:0] ns);
    tod_sec = s; tod_nsec = ns;
    @(negedge clk);
  endtask

  task automatic do_tick();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 pulse", 32'(pulse_o), 32'h0);
    rd(12'h084, d); chk("R1 tnsec/busy", d, 32'h0);
    rd(12'h070, d); chk("R1 ctrl", d, 32'h0);
    rd(12'h074, d); chk("R3 feature", d, 32'd4);
  endtask

  task automatic t_fire_ch0();
    logic [31:0] d;
    wr(12'h088, 32'd5); wr(12'h08C, 32'd2);
    wr(12'h080, 32'd10); wr(12'h084, 32'd500);
    set_time(32'd10, 30'd0);
    rd(12'h088, d); chk("R2 interval", d, 32'd5);
    rd(12'h08C, d); chk("R2 width", d, 32'd2);
    wr(12'h070, 32'h0000_0052);
    rd(12'h084, d); chk("R4 busy set", d, 32'h8000_01F4);
    rd(12'h070, d); chk("R9 cmd reads zero, mode kept", d, 32'h0000_0050);
    for (int k = 0; k < 3; k++) do_tick();
    chk("R11 low while pending", 32'(pulse_o[0]), 32'h0);
    wr(12'h080, 32'd99);
    rd(12'h080, d); chk("R8 tsec locked", d, 32'd10);
    wr(12'h084, 32'd7);
    rd(12'h084, d); chk("R8 tnsec locked", d, 32'h8000_01F4);
    set_time(32'd10, 30'd499);
    chk("R5 below target", 32'(pulse_o[0]), 32'h0);
    set_time(32'd10, 30'd500);
    chk("R5 fire at equal", 32'(pulse_o[0]), 32'h1);
    rd(12'h084, d); chk("R5 busy cleared", d, 32'h0000_01F4);
    for (int k = 1; k <= 12; k++) begin
      do_tick();
      chk("R6 ch0 train", 32'(pulse_o[0]), ((k % 6) <= 2) ? 32'h1 : 32'h0);
    end
    wr(12'h070, 32'h0000_0055);
    chk("R7 stop low", 32'(pulse_o[0]), 32'h0);
    do_tick();
    chk("R7 stays low", 32'(pulse_o[0]), 32'h0);
  endtask

  task automatic t_seconds_ch1();
    logic [31:0] d;
    wr(12'h098, 32'd3); wr(12'h09C, 32'd1);
    wr(12'h090, 32'd10); wr(12'h094, 32'd900);
    set_time(32'd9, 30'd999_999_999);
    wr(12'h070, 32'h0000_0210);
    rd(12'h070, d); chk("R9 lane0 mode preserved", d, 32'h0000_0050);
    chk("R5 earlier second", 32'(pulse_o[1]), 32'h0);
    set_time(32'd10, 30'd0);
    chk("R5 equal sec smaller ns", 32'(pulse_o[1]), 32'h0);
    set_time(32'd11, 30'd0);
    chk("R5 later sec fires", 32'(pulse_o[1]), 32'h1);
    chk("R7 ch0 unaffected", 32'(pulse_o[0]), 32'h0);
    for (int k = 1; k <= 8; k++) begin
      do_tick();
      chk("R6 ch1 train", 32'(pulse_o[1]), ((k % 4) <= 1) ? 32'h1 : 32'h0);
    end
    wr(12'h070, 32'h0000_0500);
    chk("R10 stop without enable ignored", 32'(pulse_o[1]), 32'h1);
    wr(12'h070, 32'h0000_2510);
    chk("R7 ch1 stop", 32'(pulse_o[1]), 32'h0);
    rd(12'h070, d); chk("R9 lane1 mode set", d, 32'h0000_2050);
  endtask

  task automatic t_pending_stop_ch2();
    logic [31:0] d;
    wr(12'h0A0, 32'd50);
    wr(12'h070, 32'h0002_0000);
    rd(12'h0A4, d); chk("R10 start without enable", d, 32'h0);
    wr(12'h070, 32'h0002_0010);
    rd(12'h0A4, d); chk("R4 ch2 busy", d, 32'h8000_0000);
    wr(12'h070, 32'h0005_0010);
    rd(12'h0A4, d); chk("R7 pending cleared", d, 32'h0);
    wr(12'h0A0, 32'd60);
    rd(12'h0A0, d); chk("R2 tsec writable when idle", d, 32'd60);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fire_ch0();
    t_seconds_ch1();
    t_pending_stop_ch2();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule